// File: doc/BRIEF.md
# Word-to-Byte Bus Bridge

This block sits between a CPU bus that moves 16-bit words addressed by a 15-bit word address and a peripheral bus that is 8 bits wide and addressed by a full 16-bit byte address. Word accesses that land in the slow address windows are turned into two consecutive byte cycles. The bridge creates the missing least significant address bit. It sends the odd byte first and the even byte second. On reads it keeps the first byte it receives. It holds the CPU off until both byte cycles and a fixed settling stall have passed.

Accesses to the fast windows are not split. These are the low 8 KiB and the 1 KiB block holding the scratchpad at 0x8000–0x83FF. They complete in the cycle they are presented, and their data comes from the word-wide fast side. The bridge never learns the operand size, so every slow access costs the full pair of byte cycles. This includes accesses to byte-wide devices that ignore the odd half.

The CPU side follows a valid/ready rule. `cpu_req` is the valid and `cpu_ready` is the ready, and an access completes in the cycle where both are high. While `cpu_ready` is low the CPU must hold `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` stable. Back-pressure is therefore applied only by the bridge. The peripheral side has no back-pressure: each byte strobe lasts exactly one clock, and read data is taken at the end of that clock.

Top module: `bbr_bridge`

## Requirements
- R1: Out of reset, and whenever no access is pending, `cpu_ready` is high and neither `per_rd` nor `per_wr` is asserted.
- R2: A request whose byte address is in 0x0000–0x1FFF or 0x8000–0x83FF is served in the same cycle. `cpu_ready` and `fast_sel` are high, `cpu_rdata` equals `fast_rdata`, and no byte strobe is issued.
- R3: A request to any other byte address drives `cpu_ready` low in the cycle it is decoded. `cpu_ready` then stays low for exactly 3 + STALL_CYC cycles (7 with defaults) before it is high for the completing cycle.
- R4: The first byte cycle of a split access uses the odd byte address, `{cpu_addr, 1'b1}`. On writes it carries `cpu_wdata[7:0]`.
- R5: The second byte cycle follows immediately at the even byte address, `{cpu_addr, 1'b0}`. On writes it carries `cpu_wdata[15:8]`.
- R6: A split read returns the byte from the even address in `cpu_rdata[15:8]` and the byte from the odd address in `cpu_rdata[7:0]`, during the cycle `cpu_ready` returns high.
- R7: Each split access issues exactly two one-cycle strobes: `per_rd` for reads, `per_wr` for writes, never both at once.
- R8: Requests in 0x8400–0x9FFF are split and stalled exactly like the other slow windows (two byte cycles, full stall), even though the devices there only decode even addresses.
- R9: No byte strobe is active in the decode cycle, the stall cycles or the completing cycle of a split access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU access valid |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW (15) | Word address |
| cpu_wdata | input | DW (16) | Write word |
| cpu_rdata | output | DW (16) | Read word |
| cpu_ready | output | 1 | Access completes when high with `cpu_req` |
| fast_sel | output | 1 | Fast-side select for zero-wait windows |
| fast_rdata | input | DW (16) | Read word from the fast side |
| per_addr | output | AW+1 (16) | Peripheral byte address |
| per_wdata | output | DW/2 (8) | Peripheral write byte |
| per_rdata | input | DW/2 (8) | Peripheral read byte |
| per_rd | output | 1 | Peripheral read strobe |
| per_wr | output | 1 | Peripheral write strobe |

## Verification
A sequencer stuck in the wrong state shows up at once in the stall length. `cpu_ready` then comes back early, late or never, and the bench sees this by the completing cycle of that same access. A wrong phase decode shows up in the byte cycles themselves. The bench sees `per_addr[0]` in the wrong order, the wrong data half on `per_wdata`, or a missing or extra strobe during that access. A corrupted read capture register is only visible in the one completing cycle, as swapped or stale bytes in `cpu_rdata`, so every read is compared there against an address-derived byte pattern.

// File: rtl/bbr_pkg.sv
package bbr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ODD,
    ST_EVEN,
    ST_HOLD,
    ST_DONE
  } bbr_state_e;

  typedef enum logic [1:0] {
    RG_NONE,
    RG_FAST,
    RG_SPLIT
  } bbr_region_e;

  // Fast windows in byte addresses (end values exclusive)
  localparam logic [15:0] LOW_FAST_END = 16'h2000;
  localparam logic [15:0] PAD_BASE     = 16'h8000;
  localparam logic [15:0] PAD_END      = 16'h8400;

endpackage

// File: rtl/bbr_decode.sv
module bbr_decode
  import bbr_pkg::*;
#(
  parameter int AW = 15
) (
  input  logic          cpu_req,
  input  logic [AW-1:0] cpu_addr,
  output bbr_region_e   region
);

  localparam int BAW = AW + 1;

  logic [BAW-1:0] byte_addr;
  logic           in_low;
  logic           in_pad;

  assign byte_addr = {cpu_addr, 1'b0};
  assign in_low    = byte_addr < BAW'(LOW_FAST_END);
  assign in_pad    = (byte_addr >= BAW'(PAD_BASE)) && (byte_addr < BAW'(PAD_END));

  always_comb begin
    if (!cpu_req)              region = RG_NONE;
    else if (in_low || in_pad) region = RG_FAST;
    else                       region = RG_SPLIT;
  end

endmodule

// File: rtl/bbr_seq.sv
module bbr_seq
  import bbr_pkg::*;
#(
  parameter int STALL_CYC = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  bbr_region_e region,
  output bbr_state_e  state,
  output logic        cpu_ready
);

  localparam int CW = (STALL_CYC > 1) ? $clog2(STALL_CYC + 1) : 1;

  bbr_state_e    state_q;
  logic [CW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hold_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (region == RG_SPLIT) state_q <= ST_ODD;
        ST_ODD:  state_q <= ST_EVEN;
        ST_EVEN: begin
          state_q <= ST_HOLD;
          hold_q  <= CW'(STALL_CYC - 1);
        end
        ST_HOLD: begin
          if (hold_q == '0) state_q <= ST_DONE;
          else              hold_q  <= hold_q - 1'b1;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state     = state_q;
  assign cpu_ready = ((state_q == ST_IDLE) && (region != RG_SPLIT)) ||
                     (state_q == ST_DONE);

endmodule

// File: rtl/bbr_steer.sv
module bbr_steer
  import bbr_pkg::*;
#(
  parameter int AW = 15,
  parameter int DW = 16,
  localparam int BW = DW / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bbr_state_e    state,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic [DW-1:0] fast_rdata,
  input  logic [BW-1:0] per_rdata,
  output logic [AW:0]   per_addr,
  output logic [BW-1:0] per_wdata,
  output logic          per_rd,
  output logic          per_wr,
  output logic [DW-1:0] cpu_rdata
);

  logic          odd_ph;
  logic          even_ph;
  logic [BW-1:0] lo_q;
  logic [BW-1:0] hi_q;

  assign odd_ph  = (state == ST_ODD);
  assign even_ph = (state == ST_EVEN);

  assign per_addr  = {cpu_addr, odd_ph};
  assign per_wdata = odd_ph ? cpu_wdata[BW-1:0] : cpu_wdata[DW-1:BW];
  assign per_rd    = (odd_ph || even_ph) && !cpu_we;
  assign per_wr    = (odd_ph || even_ph) && cpu_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (odd_ph && !cpu_we)  lo_q <= per_rdata;
      if (even_ph && !cpu_we) hi_q <= per_rdata;
    end
  end

  assign cpu_rdata = (state == ST_DONE) ? {hi_q, lo_q} : fast_rdata;

endmodule

// File: rtl/bbr_bridge.sv
module bbr_bridge
  import bbr_pkg::*;
#(
  parameter int AW        = 15,
  parameter int DW        = 16,
  parameter int STALL_CYC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_req,
  input  logic            cpu_we,
  input  logic [AW-1:0]   cpu_addr,
  input  logic [DW-1:0]   cpu_wdata,
  output logic [DW-1:0]   cpu_rdata,
  output logic            cpu_ready,
  output logic            fast_sel,
  input  logic [DW-1:0]   fast_rdata,
  output logic [AW:0]     per_addr,
  output logic [DW/2-1:0] per_wdata,
  input  logic [DW/2-1:0] per_rdata,
  output logic            per_rd,
  output logic            per_wr
);

  bbr_region_e region;
  bbr_state_e  state;

  bbr_decode #(.AW(AW)) u_dec (
    .cpu_req  (cpu_req),
    .cpu_addr (cpu_addr),
    .region   (region)
  );

  bbr_seq #(.STALL_CYC(STALL_CYC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .region    (region),
    .state     (state),
    .cpu_ready (cpu_ready)
  );

  bbr_steer #(.AW(AW), .DW(DW)) u_steer (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .cpu_we     (cpu_we),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .fast_rdata (fast_rdata),
    .per_rdata  (per_rdata),
    .per_addr   (per_addr),
    .per_wdata  (per_wdata),
    .per_rd     (per_rd),
    .per_wr     (per_wr),
    .cpu_rdata  (cpu_rdata)
  );

  assign fast_sel = (state == ST_IDLE) && (region == RG_FAST);

endmodule

// File: rtl/bbr_bridge_chk.sv
module bbr_bridge_chk #(
  parameter int AW        = 15,
  parameter int DW        = 16,
  parameter int STALL_CYC = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_ready,
  input logic          fast_sel,
  input logic [AW:0]   per_addr,
  input logic          per_rd,
  input logic          per_wr
);

  localparam int LOW_RUN = 3 + STALL_CYC;

  logic       strobe;
  logic [7:0] low_cnt;

  assign strobe = per_rd || per_wr;

  always_ff @(posedge clk) begin
    if (!rst_n)               low_cnt <= '0;
    else if (cpu_ready)       low_cnt <= '0;
    else if (low_cnt != 8'hFF) low_cnt <= low_cnt + 8'd1;
  end

  // R7
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(per_rd && per_wr));

  // R4
  odd_then_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && per_addr[0]) |=> (strobe && !per_addr[0] &&
                                 per_addr[AW:1] == $past(per_addr[AW:1])));

  // R5
  even_after_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !per_addr[0]) |-> $past(strobe && per_addr[0]));

  // R3
  stall_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && low_cnt != 8'd0) |-> (low_cnt == 8'(LOW_RUN)));

  // R2
  fast_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fast_sel |-> (cpu_ready && !strobe));

  // R9
  strobe_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> !cpu_ready);

endmodule

bind bbr_bridge bbr_bridge_chk #(.AW(AW), .DW(DW), .STALL_CYC(STALL_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_ready (cpu_ready),
  .fast_sel  (fast_sel),
  .per_addr  (per_addr),
  .per_rd    (per_rd),
  .per_wr    (per_wr)
);

// File: tb/sim_bbr_bridge.sv
module sim_bbr_bridge;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 15;
  localparam int DW         = 16;
  localparam int STALL      = 4;
  localparam int EXP_LOW    = 3 + STALL;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req = 1'b0;
  logic          cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata;
  logic          cpu_ready;
  logic          fast_sel;
  logic [DW-1:0] fast_rdata = '0;
  logic [AW:0]   per_addr;
  logic [7:0]    per_wdata;
  logic [7:0]    per_rdata;
  logic          per_rd;
  logic          per_wr;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bbr_bridge #(.AW(AW), .DW(DW), .STALL_CYC(STALL)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ready(cpu_ready), .fast_sel(fast_sel), .fast_rdata(fast_rdata),
    .per_addr(per_addr), .per_wdata(per_wdata), .per_rdata(per_rdata),
    .per_rd(per_rd), .per_wr(per_wr)
  );

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // Byte-wide peripheral: content derived from the address
  assign per_rdata = pat(per_addr);

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic access(input logic [15:0] ba, input bit we, input logic [15:0] wd);
    logic [15:0] fr;
    bit          fast;
    bit          win8;
    int          low;
    int          ns;
    logic [15:0] a0, a1;
    logic [7:0]  d0, d1;
    bit          r0, w0, r1, w1;
    fr   = ba ^ 16'hC3A5;
    fast = (ba < 16'h2000) || (ba >= 16'h8000 && ba < 16'h8400);
    win8 = (ba >= 16'h8400 && ba < 16'hA000);
    low = 0; ns = 0;
    a0 = '0; a1 = '0; d0 = '0; d1 = '0;
    r0 = 0; w0 = 0; r1 = 0; w1 = 0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = ba[15:1];
    cpu_wdata = wd; fast_rdata = fr;
    #1;
    if (fast) begin
      chk(cpu_ready == 1'b1, "R2", "fast ready", 32'(cpu_ready), 32'd1);
      chk(fast_sel == 1'b1, "R2", "fast_sel", 32'(fast_sel), 32'd1);
      chk(!(per_rd || per_wr), "R2", "fast strobe", 32'({per_rd, per_wr}), 32'd0);
      if (!we) chk(cpu_rdata == fr, "R2", "fast rdata", 32'(cpu_rdata), 32'(fr));
    end else begin
      chk(fast_sel == 1'b0, "R3", "slow fast_sel", 32'(fast_sel), 32'd0);
      while (!cpu_ready && low < 40) begin
        low++;
        if (per_rd || per_wr) begin
          if (ns == 0) begin a0 = per_addr; d0 = per_wdata; r0 = per_rd; w0 = per_wr; end
          if (ns == 1) begin a1 = per_addr; d1 = per_wdata; r1 = per_rd; w1 = per_wr; end
          ns++;
        end
        @(negedge clk); #1;
      end
      chk(low == EXP_LOW, win8 ? "R8" : "R3", "stall cycles", 32'(low), 32'(EXP_LOW));
      chk(ns == 2, win8 ? "R8" : "R7", "byte cycles", 32'(ns), 32'd2);
      chk(a0 == {ba[15:1], 1'b1}, "R4", "first addr", 32'(a0), 32'({ba[15:1], 1'b1}));
      chk(a1 == ba, "R5", "second addr", 32'(a1), 32'(ba));
      chk(we ? (w0 && !r0 && w1 && !r1) : (r0 && !w0 && r1 && !w1), "R7", "strobe kind",
          32'({r0, w0, r1, w1}), we ? 32'b0101 : 32'b1010);
      chk(!(per_rd || per_wr), "R9", "strobe at completion", 32'({per_rd, per_wr}), 32'd0);
      if (we) begin
        chk(d0 == wd[7:0], "R4", "first wdata", 32'(d0), 32'(wd[7:0]));
        chk(d1 == wd[15:8], "R5", "second wdata", 32'(d1), 32'(wd[15:8]));
      end else begin
        chk(cpu_rdata == {pat(ba), pat(ba | 16'h1)}, "R6", "read word",
            32'(cpu_rdata), 32'({pat(ba), pat(ba | 16'h1)}));
      end
    end
    @(negedge clk);
    cpu_req = 1'b0;
    #1;
    chk(cpu_ready == 1'b1 && !(per_rd || per_wr), "R1", "idle after access",
        32'({cpu_ready, per_rd, per_wr}), 32'b100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(cpu_ready == 1'b1 && !per_rd && !per_wr, "R1", "in reset",
        32'({cpu_ready, per_rd, per_wr}), 32'b100);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(cpu_ready == 1'b1 && !per_rd && !per_wr, "R1", "after reset",
        32'({cpu_ready, per_rd, per_wr}), 32'b100);
    // Window edges
    access(16'h1FFE, 1'b0, 16'h0000);
    access(16'h2000, 1'b0, 16'h0000);
    access(16'h7FFE, 1'b1, 16'hBEEF);
    access(16'h8000, 1'b0, 16'h0000);
    access(16'h83FE, 1'b0, 16'h0000);
    access(16'h8400, 1'b0, 16'h0000);
    access(16'h9FFE, 1'b1, 16'h1234);
    access(16'hA000, 1'b1, 16'hA55A);
    access(16'hFFFE, 1'b0, 16'h0000);
    // Sweep every 256-byte page, start and end word, read and write
    for (int p = 0; p < 256; p++) begin
      for (int k = 0; k < 2; k++) begin
        logic [15:0] ba;
        ba = 16'(p * 256 + k * 254);
        access(ba, 1'b0, 16'h0000);
        access(ba, 1'b1, ba ^ 16'h9E37);
      end
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule